// File: doc/BRIEF.md
# Fault Isolation Register Bank

The block holds one fault register of parameter width (64 bits by default) together with a mask register. Both can be reached through three addresses each: one replaces the value, one ANDs the written word into it, and one ORs the written word into it. Per-bit hardware error inputs OR into the fault register on every clock. Two action registers store whatever is written to them. The fault bits that are not masked are split into a recoverable class and a checkstop class according to the two action bits of each position, and the block raises one summary output per class.

A first-fault register records which unmasked fault bits arrived first. It is controlled by a two-state machine. In state FF_ARMED the register is zero. Transition T_CAPTURE goes to FF_HELD when newly set unmasked fault bits appear while no unmasked fault was already pending; the register then latches exactly those new bits. In FF_HELD the register holds its value until transition T_RELEASE, which any write to its address triggers: the register goes back to zero and the machine returns to FF_ARMED. A write to this address in FF_ARMED keeps the machine in FF_ARMED and the register at zero. Software reaches the whole bank through a single 64-bit configuration port. A write takes effect at the clock edge and a read is combinational from the address.

Top module: `fir_bank`

## Requirements
- R1: After reset, every readable register and every output is zero, and the first-fault machine is in FF_ARMED.
- R2: A write to register index 0 (fault) replaces the whole fault value, and indexes 0, 1 and 2 all read the fault register.
- R3: A write to index 1 (fault clear alias) ANDs the written word into the fault register. The word is used as written, not inverted.
- R4: A write to index 2 (fault set alias) ORs the written word into the fault register.
- R5: Indexes 3, 4 and 5 replace, AND into, and OR into the mask register in the same way, and all three read the mask.
- R6: Index 6 (action A) and index 7 (action B) store the written word and read it back unchanged.
- R7: unmasked_o equals fault AND NOT mask. Per bit, action A=0/B=1 is recoverable and A=0/B=0 is checkstop; any bit with A=1 belongs to neither class. recov_o is the OR of the recoverable unmasked bits and chkstop_o is the OR of the checkstop unmasked bits.
- R8: hw_err_i bits OR into the fault register on every clock, after a software write in the same cycle has been applied.
- R9: While the first-fault register (index 8) is zero and no unmasked fault bit is set, it captures the fault bits that become newly set and are unmasked, judged against the mask value before the edge. Once nonzero it holds its value. Newly set masked bits are never captured.
- R10: Any write to index 8 forces the first-fault register to zero, whatever the written value.
- R11: Writes to indexes 9 and 10 (error reports), 11 (general status) and the unused indexes 13 to 15 change nothing. These addresses read zero.
- R12: Index 12 (reset control) keeps only bit 63 of a written word; all other bits read zero.
- R13: The register index is the byte address shifted right by 3; the low three address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (7) | Byte address of the access |
| cfg_wdata | input | W (64) | Write data |
| cfg_rdata | output | W (64) | Combinational read data for cfg_addr |
| hw_err_i | input | W (64) | Per-bit hardware error set inputs |
| unmasked_o | output | W (64) | Fault bits not masked |
| recov_o | output | 1 | Some unmasked bit is in the recoverable class |
| chkstop_o | output | 1 | Some unmasked bit is in the checkstop class |

## Verification
The bench walks one set bit through all 64 positions, both as a software write and as a hardware error input, with fixed action patterns that place each bit in a known class. This shows whether the class split and the summary outputs depend on the correct bit positions. Replace, clear and set words whose bits partly overlap the current value separate the AND of the written word from the AND of its inverse, and separate the OR from a replace. Sequences involving the first-fault register cover a masked arrival, an arrival while a fault is already pending, a hardware set in the same cycle as a software clear, and a release followed by a new capture. These show whether capture is gated correctly and whether it reads the old or the new register values. Writes to the read-only and unused indexes, and accesses with nonzero low address bits, show that the decode ignores what it must.

// File: rtl/fir_pkg.sv
package fir_pkg;

    // register index map (byte address >> 3)
    localparam int FIR_IDX_FAULT     = 0;
    localparam int FIR_IDX_FAULT_CLR = 1;
    localparam int FIR_IDX_FAULT_SET = 2;
    localparam int FIR_IDX_MASK      = 3;
    localparam int FIR_IDX_MASK_CLR  = 4;
    localparam int FIR_IDX_MASK_SET  = 5;
    localparam int FIR_IDX_ACT_A     = 6;
    localparam int FIR_IDX_ACT_B     = 7;
    localparam int FIR_IDX_FIRST     = 8;
    localparam int FIR_IDX_ERR_RPT0  = 9;
    localparam int FIR_IDX_ERR_RPT1  = 10;
    localparam int FIR_IDX_GEN_STAT  = 11;
    localparam int FIR_IDX_RST_CTL   = 12;

    // one write strobe per stored target
    typedef struct packed {
        logic f_rep;
        logic f_clr;
        logic f_set;
        logic m_rep;
        logic m_clr;
        logic m_set;
        logic act_a;
        logic act_b;
        logic first;
        logic rst_ctl;
    } fir_wstb_t;

    typedef enum logic {
        FF_ARMED = 1'b0,
        FF_HELD  = 1'b1
    } fir_ff_state_e;

endpackage

// File: rtl/fir_decode.sv
module fir_decode
    import fir_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    output fir_wstb_t        stb
);

    function automatic logic hit(input logic [IDX_W-1:0] i, input int target);
        return i == IDX_W'(target);
    endfunction

    // read-only and unused indexes produce no strobe at all
    always_comb begin
        stb         = '0;
        stb.f_rep   = we && hit(idx, FIR_IDX_FAULT);
        stb.f_clr   = we && hit(idx, FIR_IDX_FAULT_CLR);
        stb.f_set   = we && hit(idx, FIR_IDX_FAULT_SET);
        stb.m_rep   = we && hit(idx, FIR_IDX_MASK);
        stb.m_clr   = we && hit(idx, FIR_IDX_MASK_CLR);
        stb.m_set   = we && hit(idx, FIR_IDX_MASK_SET);
        stb.act_a   = we && hit(idx, FIR_IDX_ACT_A);
        stb.act_b   = we && hit(idx, FIR_IDX_ACT_B);
        stb.first   = we && hit(idx, FIR_IDX_FIRST);
        stb.rst_ctl = we && hit(idx, FIR_IDX_RST_CTL);
    end

endmodule

// File: rtl/fir_reg.sv
module fir_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_rep,
    input  logic         we_clr,
    input  logic         we_set,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] d_o,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q;
    logic [W-1:0] nxt;

    // software operation first, then hardware sets on top
    always_comb begin
        nxt = q;
        if (we_rep) begin
            nxt = wdata;
        end else if (we_clr) begin
            nxt = q & wdata;
        end else if (we_set) begin
            nxt = q | wdata;
        end
        nxt = nxt | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    assign d_o = nxt;
    assign q_o = q;

    p_set_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_set && !we_rep && !we_clr) |=> ((q & $past(wdata)) == $past(wdata)));

    p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_clr && !we_rep && hw_set == '0) |=> ((q & ~$past(wdata)) == '0));

    p_hw_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(hw_set)) == $past(hw_set)));

endmodule

// File: rtl/fir_first.sv
module fir_first
    import fir_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] fault_q_i,
    input  logic [W-1:0] fault_d_i,
    input  logic [W-1:0] mask_q_i,
    output logic [W-1:0] first_o
);

    fir_ff_state_e state, state_nxt;
    logic [W-1:0]  first_q, first_nxt;
    logic [W-1:0]  arrivals;
    logic          pending;

    assign arrivals = fault_d_i & ~fault_q_i & ~mask_q_i;
    assign pending  = |(fault_q_i & ~mask_q_i);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FF_ARMED;
            first_q <= '0;
        end else begin
            state   <= state_nxt;
            first_q <= first_nxt;
        end
    end

    // transitions and register value
    always_comb begin
        state_nxt = state;
        first_nxt = first_q;
        unique case (state)
            FF_ARMED: begin
                // T_CAPTURE
                if (!clr_i && !pending && (arrivals != '0)) begin
                    state_nxt = FF_HELD;
                    first_nxt = arrivals;
                end else begin
                    first_nxt = '0;
                end
            end
            FF_HELD: begin
                // T_RELEASE
                if (clr_i) begin
                    state_nxt = FF_ARMED;
                    first_nxt = '0;
                end
            end
            default: begin
                state_nxt = FF_ARMED;
                first_nxt = '0;
            end
        endcase
    end

    assign first_o = first_q;

    p_first_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (first_q == '0));

    p_first_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FF_HELD && !clr_i) |=> $stable(first_q));

    p_capture_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FF_ARMED && pending) |=> (first_q == '0));

endmodule

// File: rtl/fir_class.sv
module fir_class #(
    parameter int W = 64
) (
    input  logic [W-1:0] fault_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] act_a_i,
    input  logic [W-1:0] act_b_i,
    output logic [W-1:0] unmasked_o,
    output logic [W-1:0] recov_vec_o,
    output logic [W-1:0] chk_vec_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic live;
        assign live           = fault_i[b] & ~mask_i[b];
        assign unmasked_o[b]  = live;
        assign recov_vec_o[b] = live & ~act_a_i[b] &  act_b_i[b];
        assign chk_vec_o[b]   = live & ~act_a_i[b] & ~act_b_i[b];
    end

endmodule

// File: rtl/fir_bank.sv
module fir_bank
    import fir_pkg::*;
#(
    parameter int W      = 64,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [W-1:0]      cfg_wdata,
    output logic [W-1:0]      cfg_rdata,
    input  logic [W-1:0]      hw_err_i,
    output logic [W-1:0]      unmasked_o,
    output logic              recov_o,
    output logic              chkstop_o
);

    localparam int IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0] idx;
    logic [2:0]       unused_addr_lsb;
    fir_wstb_t        stb;
    logic [W-1:0]     fault_q, fault_d, mask_q, mask_d_unused;
    logic [W-1:0]     act_a_q, act_b_q, first_q;
    logic             rst_bit_q;
    logic [W-1:0]     recov_vec, chk_vec;

    assign idx             = cfg_addr[ADDR_W-1:3];
    assign unused_addr_lsb = cfg_addr[2:0];

    fir_decode #(.IDX_W(IDX_W)) u_decode (
        .we  (cfg_we),
        .idx (idx),
        .stb (stb)
    );

    fir_reg #(.W(W)) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_rep (stb.f_rep),
        .we_clr (stb.f_clr),
        .we_set (stb.f_set),
        .wdata  (cfg_wdata),
        .hw_set (hw_err_i),
        .d_o    (fault_d),
        .q_o    (fault_q)
    );

    fir_reg #(.W(W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_rep (stb.m_rep),
        .we_clr (stb.m_clr),
        .we_set (stb.m_set),
        .wdata  (cfg_wdata),
        .hw_set ('0),
        .d_o    (mask_d_unused),
        .q_o    (mask_q)
    );

    fir_first #(.W(W)) u_first (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (stb.first),
        .fault_q_i (fault_q),
        .fault_d_i (fault_d),
        .mask_q_i  (mask_q),
        .first_o   (first_q)
    );

    // plainly stored registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_a_q   <= '0;
            act_b_q   <= '0;
            rst_bit_q <= 1'b0;
        end else begin
            if (stb.act_a)   act_a_q   <= cfg_wdata;
            if (stb.act_b)   act_b_q   <= cfg_wdata;
            if (stb.rst_ctl) rst_bit_q <= cfg_wdata[W-1];
        end
    end

    fir_class #(.W(W)) u_class (
        .fault_i     (fault_q),
        .mask_i      (mask_q),
        .act_a_i     (act_a_q),
        .act_b_i     (act_b_q),
        .unmasked_o  (unmasked_o),
        .recov_vec_o (recov_vec),
        .chk_vec_o   (chk_vec)
    );

    assign recov_o   = |recov_vec;
    assign chkstop_o = |chk_vec;

    // read mux: aliases read their target, others read zero
    always_comb begin
        cfg_rdata = '0;
        if (idx == IDX_W'(FIR_IDX_FAULT) || idx == IDX_W'(FIR_IDX_FAULT_CLR) ||
            idx == IDX_W'(FIR_IDX_FAULT_SET)) begin
            cfg_rdata = fault_q;
        end else if (idx == IDX_W'(FIR_IDX_MASK) || idx == IDX_W'(FIR_IDX_MASK_CLR) ||
                     idx == IDX_W'(FIR_IDX_MASK_SET)) begin
            cfg_rdata = mask_q;
        end else if (idx == IDX_W'(FIR_IDX_ACT_A)) begin
            cfg_rdata = act_a_q;
        end else if (idx == IDX_W'(FIR_IDX_ACT_B)) begin
            cfg_rdata = act_b_q;
        end else if (idx == IDX_W'(FIR_IDX_FIRST)) begin
            cfg_rdata = first_q;
        end else if (idx == IDX_W'(FIR_IDX_RST_CTL)) begin
            cfg_rdata = {rst_bit_q, {(W-1){1'b0}}};
        end
    end

    p_mask_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unmasked_o & mask_q) == '0);

    p_first_in_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.f_rep == 1'b0 && stb.f_clr == 1'b0 && $past(first_q) == '0 && first_q != '0)
        |-> ((first_q & fault_q) == first_q));

endmodule

// File: tb/test_fir_bank.sv
module test_fir_bank;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 64;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic [W-1:0]  hw_err = '0;
    logic [W-1:0]  cfg_rdata, unmasked;
    logic          recov, chkstop;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_fault = '0, m_mask = '0, m_a = '0, m_b = '0, m_first = '0;
    logic         m_rst = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fir_bank #(.W(W), .ADDR_W(AW)) i_fir_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .hw_err_i   (hw_err),
        .unmasked_o (unmasked),
        .recov_o    (recov),
        .chkstop_o  (chkstop)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_rd(input int i);
        case (i)
            0, 1, 2: return m_fault;
            3, 4, 5: return m_mask;
            6:       return m_a;
            7:       return m_b;
            8:       return m_first;
            12:      return {m_rst, {(W-1){1'b0}}};
            default: return '0;
        endcase
    endfunction

    // one clock: drive at negedge, model the edge, release at next negedge
    task automatic step(input bit we, input int i, input logic [W-1:0] wd,
                        input logic [W-1:0] hw, input int lsb = 0);
        logic [W-1:0] f, mk, arr;
        cfg_we    = we;
        cfg_addr  = AW'(i * 8 + lsb);
        cfg_wdata = wd;
        hw_err    = hw;
        @(posedge clk);
        f  = m_fault;
        mk = m_mask;
        if (we) begin
            case (i)
                0:  f = wd;
                1:  f = f & wd;
                2:  f = f | wd;
                3:  mk = wd;
                4:  mk = mk & wd;
                5:  mk = mk | wd;
                6:  m_a = wd;
                7:  m_b = wd;
                12: m_rst = wd[W-1];
                default: ;
            endcase
        end
        f   = f | hw;
        arr = f & ~m_fault & ~m_mask;
        if (we && i == 8) begin
            m_first = '0;
        end else if (m_first == '0 && (m_fault & ~m_mask) == '0) begin
            m_first = arr;
        end
        m_fault = f;
        m_mask  = mk;
        @(negedge clk);
        cfg_we = 1'b0;
        hw_err = '0;
    endtask

    task automatic check_outs(input string tag);
        logic [W-1:0] u;
        u = m_fault & ~m_mask;
        check({tag, " unmasked"}, unmasked, u);
        check({tag, " recov"}, W'(recov), W'(|(u & ~m_a & m_b)));
        check({tag, " chkstop"}, W'(chkstop), W'(|(u & ~m_a & ~m_b)));
    endtask

    task automatic check_rd(input string tag, input int i, input int lsb = 0);
        cfg_addr = AW'(i * 8 + lsb);
        #1;
        check($sformatf("%s idx%0d", tag, i), cfg_rdata, model_rd(i));
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 16; i++) check_rd(tag, i);
        check_outs(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] pa;
        pa = 64'hA5A5_0F0F_1234_8001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2 replace, first fault captures
        step(1, 0, pa, '0);
        check_all("R2 replace");
        check_rd("R9 first capture", 8);
        step(1, 0, 64'h1, '0);
        check_rd("R2 replace again", 0);
        check_rd("R9 first held", 8);

        // R10 any write zeroes first fault
        step(1, 8, '1, '0);
        check_rd("R10 first cleared", 8);

        // R3 / R4 aliases
        step(1, 0, pa, '0);
        step(1, 1, 64'hFFFF_0000_FFFF_0000, '0);
        check_all("R3 clear alias");
        step(1, 2, 64'h0000_00F0_0000_000F, '0);
        check_all("R4 set alias");

        // R5 mask aliases
        step(1, 3, 64'hFF00_FF00_FF00_FF00, '0);
        check_all("R5 mask replace");
        step(1, 4, 64'hF0F0_F0F0_0000_FFFF, '0);
        check_all("R5 mask clear");
        step(1, 5, 64'h0000_0000_0000_0003, '0);
        check_all("R5 mask set");
        step(1, 3, '0, '0);

        // R6 action registers, R7 class sweep over every bit
        step(1, 6, 64'h5555_5555_5555_5555, '0);
        step(1, 7, 64'h3333_3333_3333_3333, '0);
        check_rd("R6 action A", 6);
        check_rd("R6 action B", 7);
        for (int b = 0; b < W; b++) begin
            step(1, 0, W'(1) << b, '0);
            check_outs($sformatf("R7 bit%0d", b));
        end
        step(1, 0, '1, '0);
        step(1, 3, 64'hFFFF_FFFF_FFFF_FFF0, '0);
        check_outs("R7 masked mix");
        step(1, 3, '0, '0);

        // R8 hardware sets every bit, also under a clearing write
        for (int b = 0; b < W; b++) begin
            step(1, 0, '0, '0);
            step(0, 0, '0, W'(1) << b);
            check_rd($sformatf("R8 hw bit%0d", b), 0);
        end
        step(1, 1, '0, 64'h20);
        check_rd("R8 hw after clear", 0);

        // R9 gating: masked arrival, pending fault, then release and recapture
        step(1, 0, '0, '0);
        step(1, 8, '0, '0);
        step(1, 3, 64'hF, '0);
        step(0, 0, '0, 64'h4);
        check_rd("R9 masked not captured", 8);
        step(1, 3, '0, '0);
        step(0, 0, '0, 64'h100);
        check_rd("R9 pending blocks capture", 8);
        step(1, 0, '0, '0);
        step(0, 0, '0, 64'h8000_0000_0000_0000);
        check_rd("R9 capture new", 8);
        step(1, 8, 64'h1234, 64'h2);
        check_rd("R10 write beats capture", 8);
        check_rd("R10 fault kept", 0);

        // R11 ignored addresses
        step(1, 6, '0, '0);
        step(1, 7, '0, '0);
        for (int i = 9; i < 16; i++) begin
            if (i != 12) begin
                step(1, i, '1, '0);
                check_all($sformatf("R11 ignored idx%0d", i));
            end
        end

        // R12 reset control keeps only bit 63
        step(1, 12, '1, '0);
        check_rd("R12 rst ctl", 12);
        step(1, 12, 64'h7FFF_FFFF_FFFF_FFFF, '0);
        check_rd("R12 rst ctl low", 12);

        // R13 low address bits ignored
        step(1, 6, 64'hDEAD_BEEF_0000_0042, '0, 5);
        check_rd("R13 lsb write", 6, 3);
        check_rd("R13 lsb read", 6, 7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule